// File: doc/BRIEF.md
# PWM Fault Gate with Period-Aligned Restart

This block sits between a PWM period/duty generator and the output pins of a half- or full-bridge driver. It takes up to four raw PWM waveforms, grouped as two complementary pairs. When an external fault input goes high, it cuts every running pulse at once. It then drives each pair into a safe state chosen by software: driven low, driven high, or released (output enable removed). A latched shutdown flag records the event.

The flag can clear in two ways. In automatic mode it clears as soon as the fault has gone. In manual mode it clears when software writes a clear request after the fault has gone. In both modes the outputs stay in the safe state until the next period-start strobe, so no truncated first pulse reaches the bridge. The bridge-direction input is treated the same way: it is latched only on a period-start strobe. The generator, the comparator and the register decoder live outside this block.

The configuration word is written through a one-cycle write strobe. For the default of two pairs, its fields are:
- bits [1:0]: safe state of pair 0 (channels 0 and 2).
- bits [3:2]: safe state of pair 1 (channels 1 and 3).
- bit 4: automatic restart.
- bit 5: clear request. This bit is an action and is not stored.

Top module: `pwm_fault_gate`

## Requirements
- R1: The fault input is synchronized by two flops. A high level sampled on rising edge n sets `shutdown_flag` after edge n+2, and not before.
- R2: While the outputs are stopped, each pair applies its 2-bit safe-state field to both of its channels: 00 gives out 0 with enable 1, 01 gives out 1 with enable 1, and 10 or 11 gives out 0 with enable 0.
- R3: The running pulse is cut on the same edge that sets the flag, wherever the edge falls within the period. Before that edge the raw waveform still passes.
- R4: With automatic restart set, the flag clears on edge n+2 when the fault is first sampled low on edge n.
- R5: With automatic restart clear, the flag stays set until a write with bit 5 = 1 occurs while the synchronized fault is low. That write clears the flag on its own edge.
- R6: A clear request made while the synchronized fault is high is ignored, and it is not remembered after the fault goes away.
- R7: After the flag clears, the outputs hold their safe state until a period-start strobe. The strobe sampled on edge n makes the outputs follow the raw inputs from edge n.
- R8: `dir_active` takes the value of `bridge_dir` only on an edge where `period_start` is high. The channel gating follows `dir_active`, so a direction change made mid-period has no effect until the next strobe.
- R9: With `bridge_en` = 1, direction 0 passes channels 0 and 3 and forces channels 1 and 2 low. Direction 1 passes channels 1 and 2 and forces channels 0 and 3 low. With `bridge_en` = 0, all channels pass.
- R10: After reset the flag is 0, `dir_active` is 0, all safe-state fields are 00 and automatic restart is off. The outputs read 0 with all enables 1 until the first period-start strobe.
- R11: While running, `pwm_out` is the gated raw input registered one edge later, and every bit of `pwm_oe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_raw | input | 2*NUM_PAIRS | Raw PWM waveforms; pair p uses channels p and p+NUM_PAIRS |
| period_start | input | 1 | One-cycle strobe at the start of each PWM period |
| fault_in | input | 1 | Asynchronous fault level; high stops the outputs |
| bridge_en | input | 1 | Full-bridge gating enable |
| bridge_dir | input | 1 | Requested bridge direction |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wdata | input | 2*NUM_PAIRS+2 | Safe-state fields, auto-restart bit, clear-request bit |
| pwm_out | output | 2*NUM_PAIRS | Registered output values |
| pwm_oe | output | 2*NUM_PAIRS | Registered output enables |
| shutdown_flag | output | 1 | Latched shutdown status |
| dir_active | output | 1 | Bridge direction currently applied |

## Verification
Each result has a fixed latency:
- A raw waveform, a period-start strobe or a clear write shows at the outputs one rising edge after it is applied.
- A change of the fault level reaches `shutdown_flag` and the pins on the third rising edge, because of the two synchronizer flops and the flag register.
- Safe-state and auto-restart fields apply from the edge after their write.

The bench drives every input on the falling edge and samples on a later falling edge, after exactly the number of rising edges listed above. It also samples one edge early for the fault and restart paths, to show that nothing changes ahead of time.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
  typedef enum logic [1:0] {
    SAFE_LOW  = 2'b00,
    SAFE_HIGH = 2'b01,
    SAFE_OFF  = 2'b10,
    SAFE_OFF2 = 2'b11
  } safe_e;
endpackage

// File: rtl/pfg_sync.sv
module pfg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/pfg_trip_ctrl.sv
module pfg_trip_ctrl #(
  parameter int NUM_PAIRS = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   fault_s,
  input  logic                   period_start,
  input  logic                   cfg_wr_en,
  input  logic [2*NUM_PAIRS+1:0] cfg_wdata,
  input  logic                   bridge_dir,
  output logic                   flag_q,
  output logic                   run_d,
  output logic                   dir_d,
  output logic                   dir_q,
  output logic [2*NUM_PAIRS-1:0] ss_q
);
  localparam int SSW      = 2 * NUM_PAIRS;
  localparam int AUTO_BIT = SSW;
  localparam int CLR_BIT  = SSW + 1;

  logic auto_q;
  logic run_q;
  logic flag_d;
  logic clr_req;

  assign clr_req = cfg_wr_en & cfg_wdata[CLR_BIT];

  always_comb begin
    if (fault_s)      flag_d = 1'b1;
    else if (auto_q)  flag_d = 1'b0;
    else if (clr_req) flag_d = 1'b0;
    else              flag_d = flag_q;
  end

  always_comb begin
    if (flag_d)            run_d = 1'b0;
    else if (period_start) run_d = 1'b1;
    else                   run_d = run_q;
  end

  assign dir_d = period_start ? bridge_dir : dir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      run_q  <= 1'b0;
      dir_q  <= 1'b0;
      ss_q   <= '0;
      auto_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
      run_q  <= run_d;
      dir_q  <= dir_d;
      if (cfg_wr_en) begin
        ss_q   <= cfg_wdata[SSW-1:0];
        auto_q <= cfg_wdata[AUTO_BIT];
      end
    end
  end

  AST_FAULT_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    fault_s |=> flag_q); // R1
  AST_AUTO_CLEARS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (flag_q && auto_q && !fault_s) |=> !flag_q); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !auto_q && !clr_req) |=> flag_q); // R5
  AST_CLEAR_AFTER_FAULT: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_q) |-> !$past(fault_s)); // R6
  AST_RESTART_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    $rose(run_q) |-> $past(period_start)); // R7
  AST_DIR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (dir_q != $past(dir_q)) |-> $past(period_start)); // R8
endmodule

// File: rtl/pfg_pair_drive.sv
module pfg_pair_drive
  import pfg_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       raw_pri,
  input  logic       raw_sec,
  input  logic       run,
  input  logic       bridge_en,
  input  logic       dir,
  input  logic [1:0] ss,
  output logic       out_pri,
  output logic       out_sec,
  output logic       oe_pri,
  output logic       oe_sec
);
  localparam logic ODD = logic'(IDX % 2);

  logic  pass_pri, pass_sec;
  logic  safe_val, safe_oe;
  safe_e mode;

  assign mode     = safe_e'(ss);
  assign pass_pri = !bridge_en || (dir == ODD);
  assign pass_sec = !bridge_en || (dir != ODD);

  always_comb begin
    case (mode)
      SAFE_LOW:  begin safe_val = 1'b0; safe_oe = 1'b1; end
      SAFE_HIGH: begin safe_val = 1'b1; safe_oe = 1'b1; end
      default:   begin safe_val = 1'b0; safe_oe = 1'b0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_pri <= 1'b0;
      out_sec <= 1'b0;
      oe_pri  <= 1'b1;
      oe_sec  <= 1'b1;
    end else if (run) begin
      out_pri <= raw_pri & pass_pri;
      out_sec <= raw_sec & pass_sec;
      oe_pri  <= 1'b1;
      oe_sec  <= 1'b1;
    end else begin
      out_pri <= safe_val;
      out_sec <= safe_val;
      oe_pri  <= safe_oe;
      oe_sec  <= safe_oe;
    end
  end
endmodule

// File: rtl/pwm_fault_gate.sv
module pwm_fault_gate #(
  parameter int NUM_PAIRS   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [2*NUM_PAIRS-1:0] pwm_raw,
  input  logic                   period_start,
  input  logic                   fault_in,
  input  logic                   bridge_en,
  input  logic                   bridge_dir,
  input  logic                   cfg_wr_en,
  input  logic [2*NUM_PAIRS+1:0] cfg_wdata,
  output logic [2*NUM_PAIRS-1:0] pwm_out,
  output logic [2*NUM_PAIRS-1:0] pwm_oe,
  output logic                   shutdown_flag,
  output logic                   dir_active
);
  localparam int CH = 2 * NUM_PAIRS;

  logic          fault_s;
  logic          run_d;
  logic          dir_d;
  logic [CH-1:0] ss_q;

  pfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (fault_in),
    .q   (fault_s)
  );

  pfg_trip_ctrl #(.NUM_PAIRS(NUM_PAIRS)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .fault_s      (fault_s),
    .period_start (period_start),
    .cfg_wr_en    (cfg_wr_en),
    .cfg_wdata    (cfg_wdata),
    .bridge_dir   (bridge_dir),
    .flag_q       (shutdown_flag),
    .run_d        (run_d),
    .dir_d        (dir_d),
    .dir_q        (dir_active),
    .ss_q         (ss_q)
  );

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    pfg_pair_drive #(.IDX(p)) u_pair (
      .clk       (clk),
      .rst       (rst),
      .raw_pri   (pwm_raw[p]),
      .raw_sec   (pwm_raw[p+NUM_PAIRS]),
      .run       (run_d),
      .bridge_en (bridge_en),
      .dir       (dir_d),
      .ss        (ss_q[2*p+1:2*p]),
      .out_pri   (pwm_out[p]),
      .out_sec   (pwm_out[p+NUM_PAIRS]),
      .oe_pri    (pwm_oe[p]),
      .oe_sec    (pwm_oe[p+NUM_PAIRS])
    );
  end
endmodule

// File: tb/test_pwm_fault_gate.sv
module test_pwm_fault_gate;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] pwm_raw = '0;
  logic       period_start = 1'b0;
  logic       fault_in = 1'b0;
  logic       bridge_en = 1'b0;
  logic       bridge_dir = 1'b0;
  logic       cfg_wr_en = 1'b0;
  logic [5:0] cfg_wdata = '0;
  logic [3:0] pwm_out, pwm_oe;
  logic       shutdown_flag, dir_active;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  always #5 clk = ~clk;

  pwm_fault_gate i_pwm_fault_gate (
    .clk(clk), .rst(rst), .pwm_raw(pwm_raw), .period_start(period_start),
    .fault_in(fault_in), .bridge_en(bridge_en), .bridge_dir(bridge_dir),
    .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata), .pwm_out(pwm_out),
    .pwm_oe(pwm_oe), .shutdown_flag(shutdown_flag), .dir_active(dir_active)
  );

  // {raw[3:0], bridge_en, dir, expected out[3:0]}
  localparam logic [9:0] VEC [0:7] = '{
    10'b1111_0_0_1111, 10'b0101_0_1_0101, 10'b1111_1_0_1001, 10'b1111_1_1_0110,
    10'b0011_1_0_0001, 10'b1100_1_1_0100, 10'b1010_1_0_1000, 10'b0000_0_0_0000
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(logic [5:0] w);
    cfg_wr_en = 1'b1;
    cfg_wdata = w;
    tick();
    cfg_wr_en = 1'b0;
    cfg_wdata = '0;
  endtask

  task automatic strobe();
    period_start = 1'b1;
    tick();
    period_start = 1'b0;
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R10 reset state
    check("R10", "flag", 32'(shutdown_flag), 32'h0);
    check("R10", "out", 32'(pwm_out), 32'h0);
    check("R10", "oe", 32'(pwm_oe), 32'hF);
    check("R10", "dir", 32'(dir_active), 32'h0);

    // R11 / R9 vector walk, each vector with a period strobe
    for (int i = 0; i < 8; i++) begin
      pwm_raw    = VEC[i][9:6];
      bridge_en  = VEC[i][5];
      bridge_dir = VEC[i][4];
      strobe();
      check(VEC[i][5] ? "R9" : "R11", "out", 32'(pwm_out), 32'(VEC[i][3:0]));
      check("R11", "oe", 32'(pwm_oe), 32'hF);
    end

    bridge_en = 1'b0; bridge_dir = 1'b0; pwm_raw = 4'hF;
    strobe();
    cfg_write(6'h09); // pair0 high, pair1 released, manual restart

    // R1 / R3: fault latency and pulse cut
    fault_in = 1'b1;
    tick(); tick();
    check("R1", "flag early", 32'(shutdown_flag), 32'h0);
    check("R3", "out before cut", 32'(pwm_out), 32'hF);
    tick();
    check("R1", "flag set", 32'(shutdown_flag), 32'h1);
    check("R2", "safe out", 32'(pwm_out), 32'h5);
    check("R2", "safe oe", 32'(pwm_oe), 32'h5);

    // R6: clear while fault present is ignored and not remembered
    cfg_write(6'h29);
    check("R6", "flag after clear in fault", 32'(shutdown_flag), 32'h1);
    fault_in = 1'b0;
    repeat (4) tick();
    check("R6", "flag after fault gone", 32'(shutdown_flag), 32'h1);
    check("R5", "safe held", 32'(pwm_out), 32'h5);

    // R5 / R7: software clear then period-aligned restart
    cfg_write(6'h29);
    check("R5", "flag cleared", 32'(shutdown_flag), 32'h0);
    tick(); tick();
    check("R7", "still safe out", 32'(pwm_out), 32'h5);
    check("R7", "still safe oe", 32'(pwm_oe), 32'h5);
    strobe();
    check("R7", "resumed out", 32'(pwm_out), 32'hF);
    check("R7", "resumed oe", 32'(pwm_oe), 32'hF);

    // R4: automatic restart, pair0 released via code 11, pair1 low
    cfg_write(6'h13);
    fault_in = 1'b1;
    repeat (3) tick();
    check("R4", "flag set", 32'(shutdown_flag), 32'h1);
    check("R2", "code11/00 out", 32'(pwm_out), 32'h0);
    check("R2", "code11/00 oe", 32'(pwm_oe), 32'hA);
    fault_in = 1'b0;
    tick(); tick();
    check("R4", "flag not yet clear", 32'(shutdown_flag), 32'h1);
    tick();
    check("R4", "flag auto clear", 32'(shutdown_flag), 32'h0);
    check("R7", "held until strobe", 32'(pwm_oe), 32'hA);
    strobe();
    check("R7", "auto resumed", 32'(pwm_out), 32'hF);

    // R8: direction change deferred to period start
    bridge_en = 1'b1; bridge_dir = 1'b0;
    strobe();
    check("R9", "forward", 32'(pwm_out), 32'h9);
    bridge_dir = 1'b1;
    tick();
    check("R8", "mid-period out", 32'(pwm_out), 32'h9);
    check("R8", "mid-period dir", 32'(dir_active), 32'h0);
    tick();
    check("R8", "still old dir", 32'(pwm_out), 32'h9);
    strobe();
    check("R8", "new dir out", 32'(pwm_out), 32'h6);
    check("R8", "new dir", 32'(dir_active), 32'h1);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule